// File: doc/BRIEF.md
# Stride Prefetcher with Idle-Slot Issue

This block sits beside a memory controller and watches the demand read line addresses that reach it. It keeps a small table of streams. Each stream holds the last line it saw, a signed stride and a two-bit confidence count. A demand whose line lies within a stride window of a tracked stream trains that stream. Any other demand opens a new stream, taking a free entry first and otherwise the entry a round-robin pointer names. After three equal non-zero deltas in a row a stream counts as confirmed. It then asks for the line one stride past its last access. The stride may be upward or downward and one line or several.

Prefetch requests leave the block only in a cycle when the memory request port reports that it is idle, so demand traffic is never displaced. Each issued request reserves a slot in a private line buffer that is separate from any cache. The returned data lands in that slot. A demand read looks in the buffer first. A filled line is handed back and its slot is freed. A demand for a line that is still in flight is held, and the data is passed on as soon as it returns, so no duplicate request is sent.

Top module: `stride_pf`

## Requirements
- R1: After a synchronous active-low reset, `pf_valid` and `hit_valid` are low, even with `port_idle` high.
- R2: A stream is confirmed only after three equal non-zero deltas between successive demands. With two equal deltas no prefetch is offered. Deltas of either sign and with a magnitude from 1 to MAX_STRIDE lines (8 by default) are detected.
- R3: The line a confirmed stream requests is its last demand line plus its signed stride, taken modulo 2^LINE_W.
- R4: `pf_valid` is high only in cycles where `port_idle` is high, and a request counts as issued in every cycle where `pf_valid` is high.
- R5: A stream has at most one prefetch outstanding. After it issues, it offers no further request until the fill for that line has arrived.
- R6: A demand for a line that is filled in the buffer raises `hit_valid` one cycle later, with that line on `hit_line` and its data on `hit_data`. The slot is then freed, and a repeat demand for the same line does not hit.
- R7: A demand for a line that is issued but not yet filled does not hit and issues nothing. When the fill is accepted at clock edge E, `hit_valid` is raised with that line and data at the edge after E.
- R8: The buffer has 8 slots, which are allocated in FIFO order at issue. The ninth allocation overwrites the oldest slot, provided that slot is not pending. A demand for the displaced line then misses, and lines in the other slots still hit.
- R9: A stream entry that no demand touches for AGE_LIMIT cycles (256 by default) is dropped, and a prefetch it had pending is not offered.
- R10: A fill whose line matches no pending slot is ignored, and a later demand for that line does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dmd_valid | input | 1 | Demand read present this cycle |
| dmd_line | input | LINE_W | Demand line address |
| port_idle | input | 1 | Memory request port has no demand this cycle |
| fill_valid | input | 1 | Prefetch data returning |
| fill_line | input | LINE_W | Line address of the returning data |
| fill_data | input | DATA_W | Returning line data |
| pf_valid | output | 1 | Prefetch request issued this cycle |
| pf_line | output | LINE_W | Prefetch line address |
| hit_valid | output | 1 | Buffer supplies a demand line |
| hit_line | output | LINE_W | Line being supplied |
| hit_data | output | DATA_W | Data being supplied |

## Verification
The assertions take two things for granted. Every issued prefetch is eventually filled, and no two slots hold the same line, so at most one filled slot can match a demand. The stimulus respects both. Each stride sweep runs after a reset, with a single stream and a fill for every request it makes. The FIFO test places its nine streams 256 lines apart, which is far outside the stride window, so their prefetched lines never coincide.

// File: rtl/spf_pkg.sv
// Shared types for the stride prefetcher.
// Assumes nothing beyond being compiled before the modules that import it.
package spf_pkg;
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_FULL  = 2'd2
    } slot_st_e;
endpackage

// File: rtl/spf_stream_table.sv
// Stream table: trains signed strides from demand lines and picks one
// confirmed stream per cycle to request its next line.
// Assumes: streams stay farther apart than MAX_STRIDE lines, and every issued
// prefetch is eventually reported back through fill_done / fill_sid.
module spf_stream_table #(
    parameter int LINE_W     = 16,
    parameter int N_STREAMS  = 8,
    parameter int MAX_STRIDE = 8,
    parameter int AGE_LIMIT  = 256,
    localparam int SID_W = $clog2(N_STREAMS),
    localparam int STR_W = $clog2(MAX_STRIDE + 1) + 1,
    localparam int AGE_W = $clog2(AGE_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic [LINE_W-1:0] dmd_line,
    input  logic              port_idle,
    input  logic              slot_free,
    input  logic              fill_done,
    input  logic [SID_W-1:0]  fill_sid,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic [SID_W-1:0]  pf_sid
);
    logic                     valid_q [N_STREAMS];
    logic                     want_q  [N_STREAMS];
    logic                     busy_q  [N_STREAMS];
    logic [LINE_W-1:0]        last_q  [N_STREAMS];
    logic signed [STR_W-1:0]  stride_q[N_STREAMS];
    logic [1:0]               conf_q  [N_STREAMS];
    logic [AGE_W-1:0]         age_q   [N_STREAMS];
    logic [SID_W-1:0]         rr_q;

    logic [LINE_W-1:0]        diff [N_STREAMS];
    logic [N_STREAMS-1:0]     near, cand, empty;

    // Per-entry window test, issue eligibility and free-entry flags.
    for (genvar i = 0; i < N_STREAMS; i++) begin : g_entry
        assign diff[i]  = dmd_line - last_q[i];
        assign near[i]  = valid_q[i]
                       && ($signed(diff[i]) <=  $signed(LINE_W'(MAX_STRIDE)))
                       && ($signed(diff[i]) >= -$signed(LINE_W'(MAX_STRIDE)));
        assign cand[i]  = valid_q[i] && want_q[i] && !busy_q[i] && (conf_q[i] >= 2'd2);
        assign empty[i] = !valid_q[i];
    end

    logic             hit_any, free_any, cand_any;
    logic [SID_W-1:0] hit_idx, free_idx, iss_idx, victim;

    // Lowest-index priority encoders for training, allocation and issue.
    always_comb begin
        hit_any = 1'b0; free_any = 1'b0; cand_any = 1'b0;
        hit_idx = '0;   free_idx = '0;   iss_idx  = '0;
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (near[i])  begin hit_any  = 1'b1; hit_idx  = SID_W'(i); end
            if (empty[i]) begin free_any = 1'b1; free_idx = SID_W'(i); end
            if (cand[i])  begin cand_any = 1'b1; iss_idx  = SID_W'(i); end
        end
        victim = free_any ? free_idx : rr_q;
    end

    logic [LINE_W-1:0]       hit_diff;
    logic signed [STR_W-1:0] hit_str;
    logic signed [STR_W-1:0] iss_str;
    assign hit_diff = diff[hit_idx];
    assign hit_str  = STR_W'(hit_diff);
    assign iss_str  = stride_q[iss_idx];

    // Request goes out only into an idle port slot with buffer room.
    assign pf_valid = port_idle && cand_any && slot_free;
    assign pf_sid   = iss_idx;
    assign pf_line  = last_q[iss_idx] + {{(LINE_W-STR_W){iss_str[STR_W-1]}}, iss_str};

    // Ageing, outstanding tracking, training and allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
            for (int i = 0; i < N_STREAMS; i++) begin
                valid_q[i] <= 1'b0; want_q[i] <= 1'b0; busy_q[i] <= 1'b0;
                last_q[i]  <= '0;   stride_q[i] <= '0; conf_q[i] <= '0;
                age_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < N_STREAMS; i++) begin
                if (valid_q[i]) begin
                    if (age_q[i] == AGE_W'(AGE_LIMIT - 1)) valid_q[i] <= 1'b0;
                    else age_q[i] <= age_q[i] + 1'b1;
                end
                if (fill_done && fill_sid == SID_W'(i)) busy_q[i] <= 1'b0;
                if (pf_valid && iss_idx == SID_W'(i)) begin
                    want_q[i] <= 1'b0;
                    busy_q[i] <= 1'b1;
                end
            end
            if (dmd_valid) begin
                if (hit_any) begin
                    valid_q[hit_idx] <= 1'b1;
                    age_q[hit_idx]   <= '0;
                    if (hit_diff != '0) begin
                        last_q[hit_idx] <= dmd_line;
                        if (hit_str == stride_q[hit_idx]) begin
                            if (conf_q[hit_idx] != 2'd3) conf_q[hit_idx] <= conf_q[hit_idx] + 2'd1;
                            want_q[hit_idx] <= (conf_q[hit_idx] >= 2'd1);
                        end else begin
                            stride_q[hit_idx] <= hit_str;
                            conf_q[hit_idx]   <= 2'd0;
                            want_q[hit_idx]   <= 1'b0;
                        end
                    end
                end else begin
                    valid_q[victim]  <= 1'b1;
                    last_q[victim]   <= dmd_line;
                    stride_q[victim] <= '0;
                    conf_q[victim]   <= 2'd0;
                    want_q[victim]   <= 1'b0;
                    busy_q[victim]   <= 1'b0;
                    age_q[victim]    <= '0;
                    rr_q             <= rr_q + 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < N_STREAMS; i++) begin : g_chk
        AST_CONFIRMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[i] && conf_q[i] >= 2'd2) |-> (stride_q[i] != '0)); // R2
        AST_AGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[i] |-> (age_q[i] < AGE_W'(AGE_LIMIT))); // R9
        AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_valid && iss_idx == SID_W'(i) && !(dmd_valid && !hit_any && victim == SID_W'(i)))
            |=> busy_q[i]); // R5
    end
endmodule

// File: rtl/spf_line_buf.sv
// Private prefetch line buffer: slots are reserved in FIFO order at issue,
// filled on return and handed to demands that hit or wait on them.
// Assumes N_BUF is a power of two and no line is held in two slots at once.
module spf_line_buf
    import spf_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int DATA_W = 32,
    parameter int N_BUF  = 8,
    parameter int SID_W  = 3,
    localparam int BUF_W = $clog2(N_BUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [SID_W-1:0]  alloc_sid,
    output logic              slot_free,
    input  logic              dmd_valid,
    input  logic [LINE_W-1:0] dmd_line,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fill_done,
    output logic [SID_W-1:0]  fill_sid,
    output logic              hit_valid,
    output logic [LINE_W-1:0] hit_line,
    output logic [DATA_W-1:0] hit_data
);
    slot_st_e          st_q   [N_BUF];
    logic [LINE_W-1:0] line_q [N_BUF];
    logic [DATA_W-1:0] data_q [N_BUF];
    logic [SID_W-1:0]  sid_q  [N_BUF];
    logic              claim_q[N_BUF];
    logic [BUF_W-1:0]  wr_q;

    logic [N_BUF-1:0] dmd_full_m, dmd_pend_m, fill_m, ready;

    // Per-slot match flags against the demand and the fill.
    for (genvar i = 0; i < N_BUF; i++) begin : g_slot
        assign dmd_full_m[i] = dmd_valid  && st_q[i] == SLOT_FULL && line_q[i] == dmd_line;
        assign dmd_pend_m[i] = dmd_valid  && st_q[i] == SLOT_PEND && line_q[i] == dmd_line;
        assign fill_m[i]     = fill_valid && st_q[i] == SLOT_PEND && line_q[i] == fill_line;
        assign ready[i]      = st_q[i] == SLOT_FULL && claim_q[i];
    end

    logic [BUF_W-1:0] hf_idx, rd_idx, fm_idx;

    // Lowest-index encoders for demand hit, waiting delivery and fill.
    always_comb begin
        hf_idx = '0; rd_idx = '0; fm_idx = '0;
        for (int i = N_BUF - 1; i >= 0; i--) begin
            if (dmd_full_m[i]) hf_idx = BUF_W'(i);
            if (ready[i])      rd_idx = BUF_W'(i);
            if (fill_m[i])     fm_idx = BUF_W'(i);
        end
    end

    assign fill_done = |fill_m;
    assign fill_sid  = sid_q[fm_idx];
    assign slot_free = !(st_q[wr_q] == SLOT_PEND) && !(st_q[wr_q] == SLOT_FULL && claim_q[wr_q]);

    // Delivery, claiming, filling and FIFO allocation of slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0; hit_valid <= 1'b0; hit_line <= '0; hit_data <= '0;
            for (int i = 0; i < N_BUF; i++) begin
                st_q[i] <= SLOT_EMPTY; line_q[i] <= '0; data_q[i] <= '0;
                sid_q[i] <= '0; claim_q[i] <= 1'b0;
            end
        end else begin
            hit_valid <= 1'b0;
            if (|dmd_full_m) begin
                hit_valid    <= 1'b1;
                hit_line     <= line_q[hf_idx];
                hit_data     <= data_q[hf_idx];
                st_q[hf_idx] <= SLOT_EMPTY;
            end else if (|ready) begin
                hit_valid       <= 1'b1;
                hit_line        <= line_q[rd_idx];
                hit_data        <= data_q[rd_idx];
                st_q[rd_idx]    <= SLOT_EMPTY;
                claim_q[rd_idx] <= 1'b0;
            end
            for (int i = 0; i < N_BUF; i++)
                if (dmd_pend_m[i]) claim_q[i] <= 1'b1;
            if (fill_done) begin
                st_q[fm_idx]   <= SLOT_FULL;
                data_q[fm_idx] <= fill_data;
            end
            if (alloc) begin
                st_q[wr_q]    <= SLOT_PEND;
                line_q[wr_q]  <= alloc_line;
                sid_q[wr_q]   <= alloc_sid;
                claim_q[wr_q] <= 1'b0;
                wr_q          <= wr_q + 1'b1;
            end
        end
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dmd_full_m)); // R6
    AST_ALLOC_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> slot_free); // R8
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !alloc) |=> (st_q[$past(fm_idx)] != SLOT_PEND)); // R7
endmodule

// File: rtl/stride_pf.sv
// Stride prefetcher top: joins the stream table to the private line buffer.
// Assumes every issued prefetch is eventually answered on the fill inputs.
module stride_pf #(
    parameter int LINE_W     = 16,
    parameter int DATA_W     = 32,
    parameter int N_STREAMS  = 8,
    parameter int N_BUF      = 8,
    parameter int MAX_STRIDE = 8,
    parameter int AGE_LIMIT  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic [LINE_W-1:0] dmd_line,
    input  logic              port_idle,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [DATA_W-1:0] fill_data,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              hit_valid,
    output logic [LINE_W-1:0] hit_line,
    output logic [DATA_W-1:0] hit_data
);
    localparam int SID_W = $clog2(N_STREAMS);

    logic             slot_free, fill_done;
    logic [SID_W-1:0] fill_sid, pf_sid;

    spf_stream_table #(
        .LINE_W(LINE_W), .N_STREAMS(N_STREAMS),
        .MAX_STRIDE(MAX_STRIDE), .AGE_LIMIT(AGE_LIMIT)
    ) table_i (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
        .port_idle(port_idle), .slot_free(slot_free), .fill_done(fill_done),
        .fill_sid(fill_sid), .pf_valid(pf_valid), .pf_line(pf_line), .pf_sid(pf_sid)
    );

    spf_line_buf #(
        .LINE_W(LINE_W), .DATA_W(DATA_W), .N_BUF(N_BUF), .SID_W(SID_W)
    ) buf_i (
        .clk(clk), .rst_n(rst_n), .alloc(pf_valid), .alloc_line(pf_line),
        .alloc_sid(pf_sid), .slot_free(slot_free), .dmd_valid(dmd_valid),
        .dmd_line(dmd_line), .fill_valid(fill_valid), .fill_line(fill_line),
        .fill_data(fill_data), .fill_done(fill_done), .fill_sid(fill_sid),
        .hit_valid(hit_valid), .hit_line(hit_line), .hit_data(hit_data)
    );

    AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> port_idle); // R4
endmodule

// File: tb/stride_pf_tb_top.sv
module stride_pf_tb_top;
    localparam int LW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dmd_valid = 1'b0;
    logic [LW-1:0] dmd_line = '0;
    logic port_idle = 1'b0;
    logic fill_valid = 1'b0;
    logic [LW-1:0] fill_line = '0;
    logic [DW-1:0] fill_data = '0;
    logic pf_valid, hit_valid;
    logic [LW-1:0] pf_line, hit_line;
    logic [DW-1:0] hit_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stride_pf dut_i (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
        .port_idle(port_idle), .fill_valid(fill_valid), .fill_line(fill_line),
        .fill_data(fill_data), .pf_valid(pf_valid), .pf_line(pf_line),
        .hit_valid(hit_valid), .hit_line(hit_line), .hit_data(hit_data)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; port_idle = 1'b0; dmd_valid = 1'b0; fill_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic dmd(logic [LW-1:0] l);
        @(negedge clk); dmd_valid = 1'b1; dmd_line = l;
        @(negedge clk); dmd_valid = 1'b0;
    endtask

    task automatic fill(logic [LW-1:0] l, logic [DW-1:0] d);
        @(negedge clk); fill_valid = 1'b1; fill_line = l; fill_data = d;
        @(negedge clk); fill_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] dat(logic [LW-1:0] l);
        return 32'hD00D_0000 | DW'(l);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] base;
        // R1: reset state with the port idle
        port_idle = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "pf_valid", pf_valid, 0);
        chk("R1", "hit_valid", hit_valid, 0);

        // Sweep every stride, both signs, magnitudes 1..8
        for (int s = -8; s <= 8; s++) begin
            if (s == 0) continue;
            do_reset();
            base = 16'h4000;
            dmd(base); dmd(LW'(base + s)); dmd(LW'(base + 2 * s));
            @(negedge clk); port_idle = 1'b1; #1;
            chk("R2", "pf after two deltas", pf_valid, 0);
            @(negedge clk); port_idle = 1'b0;
            dmd(LW'(base + 3 * s)); #1;
            chk("R4", "pf with port busy", pf_valid, 0);
            @(negedge clk); port_idle = 1'b1; #1;
            chk("R2", "pf after three deltas", pf_valid, 1);
            chk("R3", "pf_line", pf_line, LW'(base + 4 * s));
            @(negedge clk); #1;
            chk("R5", "second pf while outstanding", pf_valid, 0);
            port_idle = 1'b0;
            fill(LW'(base + 4 * s), dat(LW'(base + 4 * s)));
            dmd(LW'(base + 4 * s)); #1;
            chk("R6", "hit_valid", hit_valid, 1);
            chk("R6", "hit_line", hit_line, LW'(base + 4 * s));
            chk("R6", "hit_data", hit_data, dat(LW'(base + 4 * s)));
            @(negedge clk); port_idle = 1'b1; #1;
            chk("R3", "next pf_line", pf_line, LW'(base + 5 * s));
            chk("R5", "pf after fill", pf_valid, 1);
            @(negedge clk); port_idle = 1'b0;
            dmd(LW'(base + 5 * s)); #1;
            chk("R7", "hit on in-flight line", hit_valid, 0);
            fill(LW'(base + 5 * s), dat(LW'(base + 5 * s))); #1;
            chk("R7", "hit one cycle after fill", hit_valid, 0);
            @(negedge clk); #1;
            chk("R7", "waiting hit_valid", hit_valid, 1);
            chk("R7", "waiting hit_line", hit_line, LW'(base + 5 * s));
            chk("R7", "waiting hit_data", hit_data, dat(LW'(base + 5 * s)));
            dmd(LW'(base + 4 * s)); #1;
            chk("R6", "repeat demand after hit", hit_valid, 0);
        end

        // R8: FIFO replacement with nine streams
        do_reset();
        for (int k = 0; k < 8; k++)
            for (int j = 0; j < 4; j++) dmd(LW'(256 * (k + 1) + j));
        @(negedge clk); port_idle = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1;
            chk("R8", "pf order", pf_line, LW'(256 * (k + 1) + 4));
            @(negedge clk);
        end
        port_idle = 1'b0;
        for (int k = 0; k < 8; k++) fill(LW'(256 * (k + 1) + 4), dat(LW'(256 * (k + 1) + 4)));
        for (int j = 0; j < 4; j++) dmd(LW'(256 * 9 + j));
        @(negedge clk); port_idle = 1'b1; #1;
        chk("R8", "ninth pf_valid", pf_valid, 1);
        chk("R8", "ninth pf_line", pf_line, LW'(256 * 9 + 4));
        @(negedge clk); port_idle = 1'b0;
        dmd(LW'(256 + 4)); #1;
        chk("R8", "oldest line displaced", hit_valid, 0);
        dmd(LW'(512 + 4)); #1;
        chk("R8", "second line kept", hit_valid, 1);
        chk("R8", "second line data", hit_data, dat(LW'(512 + 4)));

        // R9: stream ages out before the port frees up
        do_reset();
        for (int j = 0; j < 4; j++) dmd(LW'(16'h3000 + 2 * j));
        repeat (300) @(negedge clk);
        port_idle = 1'b1; #1;
        chk("R9", "aged stream pf", pf_valid, 0);
        @(negedge clk); port_idle = 1'b0;

        // R10: stray fill ignored
        do_reset();
        fill(16'h7777, 32'h1234_5678);
        dmd(16'h7777); #1;
        chk("R10", "hit after stray fill", hit_valid, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule